// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Status Word

This block is a serial port that sits on a simple 32-bit register bus inside a 4 KB address window. Software loads a clock divisor, writes bytes to a transmit register, and reads received bytes from a receive register. A four-bit status word shows the state of the transmitter and the receiver. The line format is 8N1: one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts sixteen ticks of a prescaler, and that prescaler counts to the divisor value.

Transmit and receive each hold a single byte. A new transmit byte is accepted only while the transmitter is idle. A received byte stays in its register until the next valid frame replaces it. Five further words hold configuration values: delay, control, interrupt enable, input-qualification cycles and receive threshold. Software can write and read these words, but they have no effect on the serial behaviour.

Top module: `uart_mmio`

## Requirements
- R1: After reset, the divisor word (offset 0x00) reads 0x00000145 and the control word (0x14) reads 0x00000100. The status word (0x0C) and the words at 0x10, 0x18, 0x1C and 0x20 read zero.
- R2: The words at 0x00, 0x10, 0x14, 0x18, 0x1C and 0x20 are read/write. A write updates only the byte lanes whose enable bit is set: enable bit k covers data bits 8k+7..8k.
- R3: A write to offset 0x04 while the transmitter is idle sends the low 8 bits of the write data as an 8N1 frame on txd. Each bit lasts 16 × max(divisor,1) clock cycles, and txd idles high.
- R4: Status bit 1 (transmit full) is 1 and status bit 0 (transmitter empty) is 0 while a frame is shifting out. After the stop bit, bit 0 is 1 and bit 1 is 0. Bit 0 is 0 from reset until the first frame completes.
- R5: A write to offset 0x04 while status bit 1 is set is ignored. No second frame follows the one in progress.
- R6: A valid frame on rxd, with its data bits sampled at mid-bit, stores its byte in the receive word (offset 0x08, bits 7..0) and sets status bit 2 (receive data available).
- R7: A read of offset 0x08 returns the last received byte and clears status bits 2 and 3.
- R8: If a valid frame completes while status bit 2 is set, its byte replaces the stored byte and status bit 3 (receive full) is set.
- R9: A frame whose stop bit samples low is discarded. The receive word and status bits 2 and 3 keep their values.
- R10: Reads of offset 0x04 and of any offset past 0x20 return zero. Writes to the status word (0x0C) and to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The transmitter is tested with a set of bytes that includes all-zero, all-one, alternating and single-bit patterns. This set shows up bit-order errors, stuck bits and misplaced start or stop bits. The receiver is tested with the same kinds of byte, and also with back-to-back frames that push the receiver into the overwrite case, and with a frame whose stop bit is low. A second divisor value checks that the bit timing scales with the divisor rather than being fixed. A sweep over all sixteen byte-enable combinations checks that the byte lanes merge independently.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;

    localparam int REG_W = 32;
    localparam int LANES = REG_W / 8;

    // word indices inside the window (byte offset / 4)
    localparam int IDX_DIV   = 0;
    localparam int IDX_TXD   = 1;
    localparam int IDX_RXD   = 2;
    localparam int IDX_STAT  = 3;
    localparam int IDX_DELAY = 4;
    localparam int IDX_CTRL  = 5;
    localparam int IDX_IRQ   = 6;
    localparam int IDX_QUAL  = 7;
    localparam int IDX_THR   = 8;
    localparam int NUM_WORDS = 9;

    localparam logic [REG_W-1:0] DIV_RESET  = 32'h0000_0145;
    localparam logic [REG_W-1:0] CTRL_RESET = 32'h0000_0100;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;

    function automatic logic [REG_W-1:0] lane_merge(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] new_v,
        input logic [LANES-1:0] be
    );
        logic [REG_W-1:0] r;
        r = old_v;
        for (int b = 0; b < LANES; b++) begin
            if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] divisor,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tg_state_t;

    tg_state_t s_d, s_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        s_d   = s_q;
        limit = (divisor == '0) ? '0 : divisor - CNT_W'(1);
        tick  = (s_q.cnt >= limit);
        s_d.cnt = tick ? '0 : s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > CNT_W'(1) && $stable(divisor)) |=> !tick);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
    parameter int DATA_W = 8,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int OS_W    = $clog2(OS);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [IDX_W-1:0]   idx;
        logic [OS_W-1:0]    os;
    } tx_state_t;

    tx_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!s_q.busy) begin
            if (load) begin
                s_d.busy  = 1'b1;
                s_d.frame = {1'b1, data, 1'b0};
                s_d.idx   = '0;
                s_d.os    = '0;
            end
        end else if (tick) begin
            if (s_q.os == OS_W'(OS - 1)) begin
                s_d.os = '0;
                if (s_q.idx == IDX_W'(FRAME_W - 1)) begin
                    s_d.busy = 1'b0;
                    done     = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + IDX_W'(1);
                end
            end else begin
                s_d.os = s_q.os + OS_W'(1);
            end
        end
        busy = s_q.busy;
        txd  = s_q.busy ? s_q.frame[s_q.idx] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> (txd == 1'b0));

    // R5
    tx_hold_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(s_q.frame));

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
    parameter int DATA_W = 8,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    import uart_mmio_pkg::*;

    localparam int OS_W  = $clog2(OS);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int HALF  = OS / 2;

    typedef struct packed {
        logic [1:0]        sync;
        rx_state_e         st;
        logic [OS_W-1:0]   os;
        logic [CNT_W-1:0]  bits;
        logic [DATA_W-1:0] shreg;
        logic              valid;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic      line;

    always_comb begin
        s_d       = s_q;
        line      = s_q.sync[1];
        s_d.sync  = {s_q.sync[0], rxd};
        s_d.valid = 1'b0;
        unique case (s_q.st)
            RX_IDLE: begin
                if (tick && !line) begin
                    s_d.st = RX_START;
                    s_d.os = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (s_q.os == OS_W'(HALF - 1)) begin
                        s_d.os   = '0;
                        s_d.bits = '0;
                        s_d.st   = line ? RX_IDLE : RX_DATA;
                    end else begin
                        s_d.os = s_q.os + OS_W'(1);
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (s_q.os == OS_W'(OS - 1)) begin
                        s_d.os    = '0;
                        s_d.shreg = {line, s_q.shreg[DATA_W-1:1]};
                        if (s_q.bits == CNT_W'(DATA_W - 1)) s_d.st = RX_STOP;
                        else s_d.bits = s_q.bits + CNT_W'(1);
                    end else begin
                        s_d.os = s_q.os + OS_W'(1);
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (s_q.os == OS_W'(OS - 1)) begin
                        s_d.os = '0;
                        if (line) begin
                            s_d.valid = 1'b1;
                            s_d.st    = RX_IDLE;
                        end else begin
                            s_d.st = RX_BREAK;
                        end
                    end else begin
                        s_d.os = s_q.os + OS_W'(1);
                    end
                end
            end
            RX_BREAK: begin
                if (line) s_d.st = RX_IDLE;
            end
            default: s_d.st = RX_IDLE;
        endcase
        valid = s_q.valid;
        data  = s_q.shreg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sync <= 2'b11;
            s_q.st   <= RX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // R9
    rx_valid_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(s_q.sync[1]));

endmodule

// File: rtl/uart_mmio.sv
module uart_mmio #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              txd,
    input  logic              rxd
);
    import uart_mmio_pkg::*;

    localparam int WORD_W = ADDR_W - 2;
    localparam int SEL_W  = $clog2(NUM_WORDS + 1);

    typedef struct packed {
        logic [REG_W-1:0] div;
        logic [REG_W-1:0] delay;
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] irq;
        logic [REG_W-1:0] qual;
        logic [REG_W-1:0] thr;
        logic [7:0]       rx_byte;
        logic             rx_avail;
        logic             rx_full;
        logic             tx_empty;
    } regs_t;

    regs_t s_d, s_q;

    logic [WORD_W-1:0] word;
    logic [SEL_W-1:0]  rsel;
    logic              wr, rd, tx_load, rx_rd;
    logic              tick, tx_busy, tx_done, rx_valid;
    logic [7:0]        rx_data;
    logic [1:0]        unused_addr_lsb;

    assign unused_addr_lsb = bus_addr[1:0];

    always_comb begin
        s_d     = s_q;
        word    = bus_addr[ADDR_W-1:2];
        rsel    = (word < WORD_W'(NUM_WORDS)) ? SEL_W'(word) : SEL_W'(NUM_WORDS);
        wr      = bus_sel && bus_we;
        rd      = bus_sel && !bus_we;
        tx_load = wr && (rsel == SEL_W'(IDX_TXD));
        rx_rd   = rd && (rsel == SEL_W'(IDX_RXD));

        if (wr) begin
            case (rsel)
                SEL_W'(IDX_DIV):   s_d.div   = lane_merge(s_q.div,   bus_wdata, bus_be);
                SEL_W'(IDX_DELAY): s_d.delay = lane_merge(s_q.delay, bus_wdata, bus_be);
                SEL_W'(IDX_CTRL):  s_d.ctrl  = lane_merge(s_q.ctrl,  bus_wdata, bus_be);
                SEL_W'(IDX_IRQ):   s_d.irq   = lane_merge(s_q.irq,   bus_wdata, bus_be);
                SEL_W'(IDX_QUAL):  s_d.qual  = lane_merge(s_q.qual,  bus_wdata, bus_be);
                SEL_W'(IDX_THR):   s_d.thr   = lane_merge(s_q.thr,   bus_wdata, bus_be);
                default: ;
            endcase
        end

        if (tx_load && !tx_busy) s_d.tx_empty = 1'b0;
        if (tx_done)             s_d.tx_empty = 1'b1;

        if (rx_rd) begin
            s_d.rx_avail = 1'b0;
            s_d.rx_full  = 1'b0;
        end
        if (rx_valid) begin
            s_d.rx_byte  = rx_data;
            s_d.rx_avail = 1'b1;
            if (s_q.rx_avail && !rx_rd) s_d.rx_full = 1'b1;
        end

        bus_rdata = '0;
        if (rd) begin
            case (rsel)
                SEL_W'(IDX_DIV):   bus_rdata = s_q.div;
                SEL_W'(IDX_RXD):   bus_rdata = {24'b0, s_q.rx_byte};
                SEL_W'(IDX_STAT):  bus_rdata = {28'b0, s_q.rx_full, s_q.rx_avail,
                                                tx_busy, s_q.tx_empty};
                SEL_W'(IDX_DELAY): bus_rdata = s_q.delay;
                SEL_W'(IDX_CTRL):  bus_rdata = s_q.ctrl;
                SEL_W'(IDX_IRQ):   bus_rdata = s_q.irq;
                SEL_W'(IDX_QUAL):  bus_rdata = s_q.qual;
                SEL_W'(IDX_THR):   bus_rdata = s_q.thr;
                default:           bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.div  <= DIV_RESET;
            s_q.ctrl <= CTRL_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    uart_tick_gen #(.CNT_W(REG_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .divisor(s_q.div), .tick(tick)
    );

    uart_tx_core #(.DATA_W(8), .OS(16)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load),
        .data(bus_wdata[7:0]), .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    uart_rx_core #(.DATA_W(8), .OS(16)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .valid(rx_valid), .data(rx_data)
    );

    // R4
    tx_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_busy && s_q.tx_empty));

    // R8
    rx_full_needs_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rx_full |-> s_q.rx_avail);

    // R7
    rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_valid) |=> (!s_q.rx_avail && !s_q.rx_full));

    // R6
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (s_q.rx_avail && s_q.rx_byte == $past(rx_data)));

endmodule

// File: tb/uart_mmio_tb.sv
`timescale 1ns/1ps
module uart_mmio_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txd;
    logic        rxd = 1'b1;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    uart_mmio dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd)
    );

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                             input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [11:0] a,
                              input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check32(req, $sformatf("read @%h", a), v, exp);
    endtask

    // waits for a start bit, samples each bit at mid-period
    task automatic capture_tx(input int bitp, output logic [7:0] b,
                              output logic framed);
        int waited = 0;
        b = '0;
        while (txd !== 1'b0 && waited < 4 * bitp) begin
            @(negedge clk);
            waited++;
        end
        repeat (bitp / 2) @(negedge clk);
        framed = (txd === 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (bitp) @(negedge clk);
            b[i] = txd;
        end
        repeat (bitp) @(negedge clk);
        framed = framed && (txd === 1'b1);
    endtask

    task automatic drive_rx(input logic [7:0] b, input logic stop_lvl,
                            input int bitp);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bitp) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bitp) @(negedge clk);
        end
        rxd = stop_lvl;
        repeat (bitp) @(negedge clk);
        rxd = 1'b1;
        repeat (bitp) @(negedge clk);
    endtask

    task automatic tx_case(input logic [7:0] b, input int bitp);
        logic [7:0] got;
        logic framed;
        logic [31:0] st;
        bus_write(12'h004, {24'hABCDEF, b}, 4'hF);
        bus_read(12'h00C, st);
        check32("R4", "status while shifting", st & 32'h3, 32'h2);
        capture_tx(bitp, got, framed);
        check32("R3", "tx byte", {24'b0, got}, {24'b0, b});
        check32("R3", "tx framing", {31'b0, framed}, 32'h1);
        repeat (bitp) @(negedge clk);
        bus_read(12'h00C, st);
        check32("R4", "status after stop", st & 32'h3, 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pat;
        logic [31:0] exp;
        logic [7:0]  got;
        logic        framed;
        int          lows;
        logic [7:0]  tx_set [6] = '{8'h00, 8'hFF, 8'h55, 8'hA5, 8'h01, 8'h80};
        logic [7:0]  rx_set [5] = '{8'h00, 8'hFF, 8'hAA, 8'h5A, 8'h81};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        expect_reg("R1", 12'h000, 32'h0000_0145);
        expect_reg("R1", 12'h014, 32'h0000_0100);
        expect_reg("R1", 12'h00C, 32'h0);
        expect_reg("R1", 12'h010, 32'h0);
        expect_reg("R1", 12'h018, 32'h0);
        expect_reg("R1", 12'h01C, 32'h0);
        expect_reg("R1", 12'h020, 32'h0);

        // R2 full-word read/write on the configuration words
        for (int k = 0; k < 5; k++) begin
            pat = 32'hA5A5_0000 ^ (32'(k + 1) * 32'h0101_0101);
            bus_write(12'(12'h010 + 4 * k), pat, 4'hF);
        end
        for (int k = 0; k < 5; k++) begin
            pat = 32'hA5A5_0000 ^ (32'(k + 1) * 32'h0101_0101);
            expect_reg("R2", 12'(12'h010 + 4 * k), pat);
        end

        // R2 byte-lane sweep over all enable patterns
        for (int be = 0; be < 16; be++) begin
            bus_write(12'h010, 32'h0, 4'hF);
            bus_write(12'h010, 32'hC3E1_96A5, 4'(be));
            exp = 32'h0;
            for (int l = 0; l < 4; l++)
                if (be[l]) exp[8*l +: 8] = 8'(32'hC3E1_96A5 >> (8 * l));
            expect_reg("R2", 12'h010, exp);
        end

        // R10 write-only, unmapped and status behaviour
        expect_reg("R10", 12'h004, 32'h0);
        expect_reg("R10", 12'h024, 32'h0);
        expect_reg("R10", 12'hFFC, 32'h0);
        bus_write(12'h00C, 32'hFFFF_FFFF, 4'hF);
        expect_reg("R10", 12'h00C, 32'h0);
        bus_write(12'h024, 32'h1234_5678, 4'hF);
        expect_reg("R10", 12'h024, 32'h0);
        expect_reg("R10", 12'h020, 32'hA5A5_0000 ^ (32'd5 * 32'h0101_0101));

        // divisor = 1: bit period 16 cycles
        bus_write(12'h000, 32'h1, 4'hF);
        expect_reg("R2", 12'h000, 32'h1);

        // R3 / R4 transmit sweep
        foreach (tx_set[i]) tx_case(tx_set[i], 16);

        // R5 write while busy is dropped
        bus_write(12'h004, 32'h0000_003C, 4'hF);
        bus_write(12'h004, 32'h0000_00C3, 4'hF);
        capture_tx(16, got, framed);
        check32("R5", "first byte kept", {24'b0, got}, 32'h3C);
        repeat (16) @(negedge clk);
        lows = 0;
        for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check32("R5", "no second frame", 32'(lows), 32'h0);

        // R6 / R7 receive sweep (tx empty bit stays 1)
        foreach (rx_set[i]) begin
            drive_rx(rx_set[i], 1'b1, 16);
            expect_reg("R6", 12'h00C, 32'h5);
            expect_reg("R7", 12'h008, {24'b0, rx_set[i]});
            expect_reg("R7", 12'h00C, 32'h1);
        end

        // R8 overwrite sets receive full
        drive_rx(8'h11, 1'b1, 16);
        drive_rx(8'h22, 1'b1, 16);
        expect_reg("R8", 12'h00C, 32'hD);
        expect_reg("R8", 12'h008, 32'h22);
        expect_reg("R7", 12'h00C, 32'h1);

        // R9 bad stop bit is discarded
        drive_rx(8'h77, 1'b0, 16);
        expect_reg("R9", 12'h00C, 32'h1);
        expect_reg("R9", 12'h008, 32'h22);
        drive_rx(8'h4D, 1'b1, 16);
        expect_reg("R9", 12'h008, 32'h4D);

        // divisor = 2: bit period 32 cycles
        bus_write(12'h000, 32'h2, 4'hF);
        tx_case(8'h96, 32);
        drive_rx(8'h69, 1'b1, 32);
        expect_reg("R6", 12'h00C, 32'h5);
        expect_reg("R7", 12'h008, 32'h69);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule